// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns host bytes into asynchronous serial frames on a single output line. The host writes a byte with a one-cycle strobe into a holding register. The frame sequencer pulls the byte from there into its own shift register at a bit boundary. While one character is on the line, the next one can already wait in the holding register. An external divider supplies a tick at sixteen times the bit rate, and the block divides that tick by sixteen itself.

Two status flags report progress. Buffer-empty says that the holding register may be written. Shift-complete says that the line has gone idle after the final stop bit. A configuration bit selects which of the two flags drives the transmit interrupt. The interrupt is a one-cycle pulse on each rising edge of the selected flag.

The frame format is set by four configuration bits: 7 or 8 data bits, parity on or off, even or odd parity, and 1 or 2 stop bits. These bits are captured when a character enters the shift register.

The sequencer states are IDLE, START, DATA, PARITY, STOP1 and STOP2. Every transition happens on a bit strobe:
- IDLE→START when the buffer holds a byte.
- START→DATA.
- DATA→PARITY or DATA→STOP1 after the last active data bit.
- PARITY→STOP1.
- STOP1→STOP2 in two-stop mode.
- STOP1 or STOP2 → START when another byte is waiting (back-to-back frames).
- STOP1 or STOP2 → IDLE when the buffer is empty.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `shift_done` is 1 and `tx_irq` is 0.
- R2: One bit on `txd` lasts exactly 16 `baud_tick` pulses. Bit boundaries come from a divider that runs freely from reset.
- R3: A frame is a start bit of 0, then the data bits least significant first, then the stop bits as 1. There is one stop bit when `cfg_stop2`=0 and two when it is 1. The line rests at 1 between frames.
- R4: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 it gives an even count of ones over the data bits plus parity; with `cfg_par_odd`=1 it gives an odd count. When `cfg_par_en`=0, no parity bit is sent.
- R5: With `cfg_len8`=0, exactly 7 data bits (`wr_data[6:0]`) are sent. `wr_data[7]` has no effect on the line, including on parity.
- R6: `buf_empty` is 0 from the cycle after a write. It returns to 1 in the cycle after the edge at which the byte moves into the shift register, and that move happens only at a bit boundary. If a write and a move fall on the same edge, the write wins and `buf_empty` stays 0.
- R7: If a byte is waiting when the last stop bit ends, its start bit follows immediately, with no idle bit in between, and `shift_done` stays 0.
- R8: `shift_done` rises only when the last stop bit ends with the buffer empty. A write while it is 1 makes it fall at the next bit boundary, that is within 16 ticks.
- R9: `tx_irq` is a one-cycle pulse, high in the cycle in which the selected flag becomes 1. `cfg_irq_sel`=0 selects `buf_empty` and `cfg_irq_sel`=1 selects `shift_done`.
- R10: Changes to the format inputs during a frame do not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_irq_sel | input | 1 | Interrupt source: 0 buffer-empty, 1 shift-complete |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register may be written |
| shift_done | output | 1 | Line idle after final stop bit |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
`txd`, `shift_done` and the rising edge of `buf_empty` change in the cycle after the clock edge that samples the sixteenth tick of a bit. `buf_empty` falls one cycle after a write. `tx_irq` is high in the same cycle as the flag edge it reports, because it is formed from registered values. The bench keeps a behavioural reference built from a tick counter and a queue of pending line bits. The reference advances at each rising edge, and the bench compares all four outputs at each falling edge, so every expected value is taken one edge after its cause. Directed checks measure the bit length in ticks and the delay before shift-complete falls.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_t;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } tx_fmt_t;

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    output logic bit_stb
);
    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (baud_tick) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign bit_stb = baud_tick && (phase_q == LAST);
endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_empty <= 1'b1;
        end else begin
            if (wr_en) begin
                hold_data <= wr_data;
            end
            // a write on the same edge as a take keeps the buffer full
            if (wr_en) begin
                hold_empty <= 1'b0;
            end else if (take) begin
                hold_empty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              hold_empty,
    input  logic [DATA_W-1:0] hold_data,
    input  tx_fmt_t           fmt_in,
    output logic              take,
    output logic              txd,
    output logic              shift_done
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST8 = BW'(DATA_W - 1);
    localparam logic [BW-1:0] LAST7 = BW'(DATA_W - 2);
    localparam logic [DATA_W-1:0] MASK7 = {1'b0, {(DATA_W-1){1'b1}}};

    tx_state_t       state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [BW-1:0]   bitn_q;
    tx_fmt_t         fmt_q;
    logic            par_q;
    logic            last_data;
    logic [DATA_W-1:0] active_bits;

    assign last_data   = (bitn_q == (fmt_q.len8 ? LAST8 : LAST7));
    assign active_bits = hold_data & (fmt_in.len8 ? '1 : MASK7);

    // next state and buffer handoff
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        if (bit_stb) begin
            unique case (state_q)
                TX_IDLE: begin
                    if (!hold_empty) begin
                        take    = 1'b1;
                        state_d = TX_START;
                    end
                end
                TX_START:  state_d = TX_DATA;
                TX_DATA: begin
                    if (last_data) begin
                        state_d = fmt_q.par_en ? TX_PARITY : TX_STOP1;
                    end
                end
                TX_PARITY: state_d = TX_STOP1;
                TX_STOP1: begin
                    if (fmt_q.stop2) begin
                        state_d = TX_STOP2;
                    end else if (!hold_empty) begin
                        take    = 1'b1;
                        state_d = TX_START;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end
                TX_STOP2: begin
                    if (!hold_empty) begin
                        take    = 1'b1;
                        state_d = TX_START;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end
                default:   state_d = TX_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TX_IDLE;
            shreg_q    <= '0;
            bitn_q     <= '0;
            fmt_q      <= '0;
            par_q      <= 1'b0;
            shift_done <= 1'b1;
        end else begin
            state_q <= state_d;
            if (take) begin
                shreg_q <= hold_data;
                fmt_q   <= fmt_in;
                par_q   <= (^active_bits) ^ fmt_in.par_odd;
                bitn_q  <= '0;
            end else if (bit_stb && state_q == TX_DATA) begin
                shreg_q <= shreg_q >> 1;
                bitn_q  <= bitn_q + 1'b1;
            end
            if (take) begin
                shift_done <= 1'b0;
            end else if (state_d == TX_IDLE && state_q != TX_IDLE) begin
                shift_done <= 1'b1;
            end
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg_q[0];
            TX_PARITY: txd = par_q;
            TX_STOP1:  txd = 1'b1;
            TX_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_irq_sel,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_done,
    output logic              tx_irq
);
    logic              bit_stb;
    logic              take;
    logic [DATA_W-1:0] hold_data;
    tx_fmt_t           fmt_in;
    logic              irq_src;
    logic              irq_src_q;

    assign fmt_in = '{len8: cfg_len8, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, stop2: cfg_stop2};

    uart_tx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .bit_stb   (bit_stb)
    );

    uart_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_empty (buf_empty)
    );

    uart_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .hold_empty (buf_empty),
        .hold_data  (hold_data),
        .fmt_in     (fmt_in),
        .take       (take),
        .txd        (txd),
        .shift_done (shift_done)
    );

    // interrupt: rising edge of the selected flag
    assign irq_src = cfg_irq_sel ? shift_done : buf_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_src_q <= 1'b1;
        end else begin
            irq_src_q <= irq_src;
        end
    end

    assign tx_irq = irq_src & ~irq_src_q;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic bit_stb,
    input logic cfg_irq_sel,
    input logic txd,
    input logic buf_empty,
    input logic shift_done,
    input logic tx_irq
);
    // R6
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (cfg_irq_sel ? shift_done : buf_empty));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb) |-> $stable(txd));

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |-> txd);

    // R8
    done_at_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(shift_done) |-> $past(bit_stb));
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .bit_stb     (bit_stb),
    .cfg_irq_sel (cfg_irq_sel),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_done  (shift_done),
    .tx_irq      (tx_irq)
);

// File: tb/uart_tx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cfg_len8 = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_irq_sel = 1'b0;
    logic       txd, buf_empty, shift_done, tx_irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    string cur_tag = "R3";

    always #2.5 clk = ~clk;

    uart_tx_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_irq_sel(cfg_irq_sel),
        .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // behavioural reference
    int   m_tcnt;
    bit   m_empty, m_done, m_txd, m_selq;
    bit [7:0] m_buf;
    bit   line_q[$];

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_tcnt = 0; m_empty = 1; m_done = 1; m_txd = 1; m_selq = 1; m_buf = 0;
            line_q.delete();
        end else begin
            bit stb;
            stb = baud_tick && (m_tcnt == 15);
            if (baud_tick) m_tcnt = (m_tcnt + 1) % 16;
            m_selq = cfg_irq_sel ? m_done : m_empty;
            if (stb) begin
                if (line_q.size() > 0) begin
                    m_txd = line_q.pop_front();
                end else if (!m_empty) begin
                    int nb;
                    int ones;
                    nb = cfg_len8 ? 8 : 7;
                    ones = 0;
                    line_q.push_back(1'b0);
                    for (int i = 0; i < nb; i++) begin
                        line_q.push_back(m_buf[i]);
                        ones += m_buf[i];
                    end
                    if (cfg_par_en) line_q.push_back(bit'(ones % 2) ^ cfg_par_odd);
                    line_q.push_back(1'b1);
                    if (cfg_stop2) line_q.push_back(1'b1);
                    m_txd = line_q.pop_front();
                    m_empty = 1; m_done = 0;
                end else begin
                    m_txd = 1; m_done = 1;
                end
            end
            if (wr_en) begin m_buf = wr_data; m_empty = 0; end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_tag, "txd", txd, m_txd);
            check("R6", "buf_empty", buf_empty, m_empty);
            check("R8", "shift_done", shift_done, m_done);
            check("R9", "tx_irq", tx_irq, (cfg_irq_sel ? m_done : m_empty) & ~m_selq);
        end
    end

    // baud tick every second cycle
    initial begin
        forever begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(shift_done && buf_empty));
        repeat (5) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d);
        write_byte(d);
        wait_idle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        finish_run();
    end

    initial begin
        int ticks;
        int waitc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "txd", txd, 1);
        check("R1", "buf_empty", buf_empty, 1);
        check("R1", "shift_done", shift_done, 1);
        check("R1", "tx_irq", tx_irq, 0);

        // R2 start bit width in ticks
        cur_tag = "R2";
        write_byte(8'h01);
        do @(negedge clk); while (txd);
        ticks = 0;
        forever begin
            @(posedge clk); if (baud_tick) ticks++;
            @(negedge clk); if (txd) break;
        end
        check("R2", "start bit ticks", ticks, 16);
        wait_idle();

        // R3 plain formats
        cur_tag = "R3";
        send(8'hA5);
        cfg_stop2 = 1'b1;
        send(8'h3C);
        cfg_stop2 = 1'b0;

        // R4 parity
        cur_tag = "R4";
        cfg_par_en = 1'b1;
        send(8'h07);
        cfg_par_odd = 1'b1;
        send(8'h07);
        send(8'h00);
        cfg_par_odd = 1'b0;
        cfg_stop2 = 1'b1;
        send(8'hFF);
        cfg_stop2 = 1'b0;

        // R5 seven-bit mode, top bit ignored
        cur_tag = "R5";
        cfg_len8 = 1'b0;
        send(8'h80);
        send(8'hFF);
        cfg_par_en = 1'b0;
        send(8'hD5);
        cfg_len8 = 1'b1;

        // R7 back-to-back frames
        cur_tag = "R7";
        cfg_irq_sel = 1'b0;
        write_byte(8'h96);
        repeat (3) @(negedge clk);
        write_byte(8'h69);
        do @(negedge clk); while (!buf_empty);
        write_byte(8'hF0);
        wait_idle();

        // R9 interrupt on shift-complete
        cur_tag = "R9";
        cfg_irq_sel = 1'b1;
        write_byte(8'h11);
        do @(negedge clk); while (!buf_empty);
        write_byte(8'h22);
        wait_idle();

        // R10 format change mid-frame
        cur_tag = "R10";
        cfg_irq_sel = 1'b0;
        write_byte(8'h5A);
        repeat (60) @(negedge clk);
        cfg_len8 = 1'b0; cfg_par_en = 1'b1; cfg_stop2 = 1'b1;
        wait_idle();
        cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;

        // R8 shift-complete falls within one bit after a write, several offsets
        cur_tag = "R8";
        for (int k = 0; k < 4; k++) begin
            repeat (k * 7 + 1) @(negedge clk);
            write_byte(8'h40 + 8'(k));
            waitc = 1;
            while (shift_done && waitc < 100) begin @(negedge clk); waitc++; end
            check("R8", "cycles until shift_done falls <= 33", (waitc <= 33) ? 1 : 0, 1);
            wait_idle();
        end

        finish_run();
    end
endmodule